// File: doc/BRIEF.md
# RMII Receive Preamble Handler

This block takes the serial bit stream of a 10 Mb/s receiver, after line decoding, and turns it into the two-bit receive data and combined carrier/data-valid flag of a reduced media-independent interface (RMII). Received bits are paired into dibits. The first bit of each pair goes on `rxd[0]`, and every byte is sent least-significant bit first. Each dibit is held for one 10 Mb/s dibit period, which is ten cycles of the 50 MHz reference clock. No scrambling or descrambling is applied, so data bits reach the MAC unchanged.

A single control input, sampled at frame start, selects how the preamble is handled. With `pre_keep` high, every received byte is forwarded, and `crs_dv` rises together with the first preamble dibit. With `pre_keep` low, the preamble is discarded. `crs_dv` then stays low until the byte-aligned start frame delimiter 0xD5 is found. It rises with the first dibit of that delimiter, so the first byte the MAC sees is the delimiter itself, followed directly by the frame body.

The output lags the input by exactly one byte. This lets the block decide whether a byte is kept before the byte's first dibit is driven. When the receive-valid input drops, the buffered byte is drained at the same dibit cadence, and then `crs_dv` falls.

Top module: `rmii_rx_preamble`

## Requirements
- R1: After reset, `crs_dv` is 0 and `rxd` is 2'b00.
- R2: Dibit k (k = 0..3) of a byte carries byte bits 2k on `rxd[0]` and 2k+1 on `rxd[1]`; bits arrive on `rx_bit` least-significant first.
- R3: With `pre_keep` = 1 at frame start, every complete received byte is output. `crs_dv` rises with the first preamble dibit. A dibit completed at receive dibit event e is driven at event e+4.
- R4: With `pre_keep` = 0, `crs_dv` stays low during the preamble. It rises with the first dibit of the delimiter byte 0xD5 (dibits 01, 01, 01, 11). All bytes after the delimiter follow without a gap.
- R5: The delimiter is recognised only on byte boundaries counted from the first bit of the frame. A 0xD5 pattern at any other bit offset never raises `crs_dv`.
- R6: With `pre_keep` = 0, a frame that ends without an aligned delimiter never raises `crs_dv`.
- R7: `rxd` and `crs_dv` change only at dibit events. With input bits every `DIB_CYC`/2 cycles, each output dibit is held for `DIB_CYC` cycles.
- R8: After `rx_valid` falls, the buffered dibits continue to be driven every `DIB_CYC` cycles after the last receive dibit event. `crs_dv` falls at the first dibit boundary after the last complete byte. Trailing bits that do not complete a byte are dropped.
- R9: `pre_keep` is sampled only when a frame starts. Changing it during a frame has no effect on that frame.
- R10: `rxd` is 2'b00 whenever `crs_dv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Carrier/valid flag of the decoded receive stream |
| rx_bit_stb | input | 1 | One-cycle strobe marking a new decoded bit |
| rx_bit | input | 1 | Decoded receive bit, valid with `rx_bit_stb` |
| pre_keep | input | 1 | 1 forwards the preamble, 0 strips it up to the delimiter |
| rxd | output | 2 | RMII receive dibit |
| crs_dv | output | 1 | RMII carrier sense / data valid |

## Verification
Every receive dibit event is a known edge: the edge on which the second bit of a pair is strobed. The outputs for event e are registered on that edge and show the byte completed four events earlier. After `rx_valid` drops, events fall exactly `DIB_CYC` edges apart, counted from the last receive event. The reference model in the bench updates its expected `rxd`/`crs_dv` one time step after each event edge, and compares on every falling edge. This catches a change one cycle early or late, as well as a wrong dibit. The model derives kept bytes from the bit list alone, so misaligned delimiters, mode flips and truncated tails are predicted without reference to the design.

// File: rtl/rpre_pkg.sv
package rpre_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_FWD   = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_e;

  typedef logic [1:0] dibit_t;

endpackage

// File: rtl/rpre_bit_pack.sv
module rpre_bit_pack
  import rpre_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   bit_stb,
  input  logic   bit_val,
  output logic   dib_stb,
  output dibit_t dib_val
);

  logic half_q, half_d;
  logic phase_q, phase_d;

  always_comb begin
    half_d  = half_q;
    phase_d = phase_q;
    if (clr) begin
      phase_d = 1'b0;
    end else if (bit_stb) begin
      if (!phase_q) half_d = bit_val;
      phase_d = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      half_q  <= half_d;
      phase_q <= phase_d;
    end
  end

  // second bit of a pair completes the dibit; first bit lands on bit 0
  assign dib_stb = bit_stb & phase_q & ~clr;
  assign dib_val = {bit_val, half_q};

endmodule

// File: rtl/rpre_frame_ctl.sv
module rpre_frame_ctl
  import rpre_pkg::*;
#(
  parameter int              BYTE_W  = 8,
  parameter int              DIB_CYC = 10,
  parameter logic [BYTE_W-1:0] SFD   = 8'hD5
)(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_valid,
  input  logic      pass_pre,
  input  logic      dib_stb,
  input  dibit_t    dib_val,
  output logic      pack_clr,
  output logic      evt,
  output dibit_t    out_dibit,
  output logic      out_keep,
  output rx_state_e state_o
);

  localparam int NDIB  = BYTE_W / 2;
  localparam int IDX_W = $clog2(NDIB);
  localparam int TMR_W = $clog2(DIB_CYC);
  localparam int ASM_W = BYTE_W - 2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NDIB - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(DIB_CYC - 1);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [ASM_W-1:0]  asm_q, asm_d;
  logic [BYTE_W-1:0] held_q, held_d;
  logic              keep_q, keep_d;

  logic              active, dib_hit, drain_hit, sfd_hit;
  logic [BYTE_W-1:0] byte_now;

  assign active    = (state_q == ST_HUNT) || (state_q == ST_FWD);
  assign dib_hit   = active & dib_stb;
  assign drain_hit = (state_q == ST_DRAIN) && (tmr_q == TMR_LAST);
  assign evt       = dib_hit | drain_hit;
  assign byte_now  = {dib_val, asm_q};
  assign sfd_hit   = (byte_now == SFD);
  assign pack_clr  = ~active;

  // the byte completed one byte-time ago, slot chosen by idx
  assign out_keep  = keep_q;
  assign out_dibit = keep_q ? held_q[{idx_q, 1'b0} +: 2] : 2'b00;
  assign state_o   = state_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tmr_d   = tmr_q;
    asm_d   = asm_q;
    held_d  = held_q;
    keep_d  = keep_q;

    if (evt)                    tmr_d = '0;
    else if (tmr_q != TMR_LAST) tmr_d = tmr_q + 1'b1;

    unique case (state_q)
      ST_IDLE: begin
        idx_d  = '0;
        keep_d = 1'b0;
        if (rx_valid) state_d = pass_pre ? ST_FWD : ST_HUNT;
      end
      ST_HUNT, ST_FWD: begin
        if (!rx_valid) begin
          state_d = ST_DRAIN;
        end else if (dib_stb) begin
          idx_d = idx_q + 1'b1;
          if (idx_q != IDX_LAST) begin
            asm_d[{idx_q, 1'b0} +: 2] = dib_val;
          end else begin
            held_d = byte_now;
            keep_d = (state_q == ST_FWD) || sfd_hit;
            if ((state_q == ST_HUNT) && sfd_hit) state_d = ST_FWD;
          end
        end
      end
      ST_DRAIN: begin
        if (drain_hit) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) keep_d = 1'b0;
          if ((idx_q == '0) && !keep_q) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      tmr_q   <= '0;
      asm_q   <= '0;
      held_q  <= '0;
      keep_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tmr_q   <= tmr_d;
      asm_q   <= asm_d;
      held_q  <= held_d;
      keep_q  <= keep_d;
    end
  end

  AST_SFD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(keep_q) && ($past(state_q) == ST_HUNT)) |-> (held_q == SFD)); // R4

  AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT) |-> !keep_q); // R6

endmodule

// File: rtl/rpre_rmii_drive.sv
module rpre_rmii_drive
  import rpre_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   evt,
  input  dibit_t dibit_in,
  input  logic   keep_in,
  output dibit_t rxd,
  output logic   crs_dv
);

  dibit_t rxd_q, rxd_d;
  logic   crs_q, crs_d;

  always_comb begin
    rxd_d = rxd_q;
    crs_d = crs_q;
    if (evt) begin
      rxd_d = dibit_in;
      crs_d = keep_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q <= 2'b00;
      crs_q <= 1'b0;
    end else begin
      rxd_q <= rxd_d;
      crs_q <= crs_d;
    end
  end

  assign rxd    = rxd_q;
  assign crs_dv = crs_q;

  AST_QUIET_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !crs_q |-> (rxd_q == 2'b00)); // R10

endmodule

// File: rtl/rmii_rx_preamble.sv
module rmii_rx_preamble
  import rpre_pkg::*;
#(
  parameter int              BYTE_W  = 8,
  parameter int              DIB_CYC = 10,
  parameter logic [BYTE_W-1:0] SFD   = 8'hD5
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic       rx_bit_stb,
  input  logic       rx_bit,
  input  logic       pre_keep,
  output logic [1:0] rxd,
  output logic       crs_dv
);

  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic      pack_clr, dib_stb, evt, out_keep;
  dibit_t    dib_val, out_dibit;
  rx_state_e ctl_state;

  rpre_bit_pack u_pack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (pack_clr),
    .bit_stb (rx_bit_stb & rx_valid),
    .bit_val (rx_bit),
    .dib_stb (dib_stb),
    .dib_val (dib_val)
  );

  rpre_frame_ctl #(
    .BYTE_W  (BYTE_W),
    .DIB_CYC (DIB_CYC),
    .SFD     (SFD)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_valid  (rx_valid),
    .pass_pre  (pre_keep),
    .dib_stb   (dib_stb),
    .dib_val   (dib_val),
    .pack_clr  (pack_clr),
    .evt       (evt),
    .out_dibit (out_dibit),
    .out_keep  (out_keep),
    .state_o   (ctl_state)
  );

  rpre_rmii_drive u_drive (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (evt),
    .dibit_in (out_dibit),
    .keep_in  (out_keep),
    .rxd      (rxd),
    .crs_dv   (crs_dv)
  );

  AST_IDLE_NO_CRS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_state == ST_IDLE) |-> !crs_dv); // R8

endmodule

// File: tb/sim_rmii_rx_preamble.sv
module sim_rmii_rx_preamble;

  logic       clk;
  logic       rst_n;
  logic       rx_valid, rx_bit_stb, rx_bit, pre_keep;
  logic [1:0] rxd;
  logic       crs_dv;

  rmii_rx_preamble u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit_stb(rx_bit_stb),
    .rx_bit(rx_bit), .pre_keep(pre_keep), .rxd(rxd), .crs_dv(crs_dv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    checking = 0;
  string tag = "R1";
  logic [1:0] exp_rxd = 2'b00;
  logic       exp_crs = 1'b0;

  bit fb[$];
  bit mb[$];
  bit mk[$];
  int mnbytes;

  always @(negedge clk) begin
    if (checking) begin
      n_cmp++;
      if (crs_dv !== exp_crs || rxd !== exp_rxd) begin
        n_bad++;
        $display("FAIL %s cyc %0d: rxd=%b crs_dv=%b expected rxd=%b crs_dv=%b",
                 tag, cyc, rxd, crs_dv, exp_rxd, exp_crs);
      end
      n_cmp++;
      if (!crs_dv && rxd !== 2'b00) begin
        n_bad++;
        $display("FAIL R10 cyc %0d: rxd=%b with crs_dv low, expected 00", cyc, rxd);
      end
    end
  end

  function automatic void add_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) fb.push_back(v[i]);
  endfunction

  task automatic set_exp(int e);
    int b, s;
    b = e / 4 - 1;
    s = e % 4;
    if (b >= 0 && b < mnbytes && mk[b]) begin
      exp_crs = 1'b1;
      exp_rxd = {mb[8*b+2*s+1], mb[8*b+2*s]};
    end else begin
      exp_crs = 1'b0;
      exp_rxd = 2'b00;
    end
  endtask

  task automatic run_frame(bit keep_pre, int flip_at, string t);
    int  nb, e, last;
    bit  seen;
    logic [7:0] v;
    mb = fb;
    fb.delete();
    mk.delete();
    nb = mb.size();
    mnbytes = nb / 8;
    seen = keep_pre;
    for (int b = 0; b < mnbytes; b++) begin
      for (int i = 0; i < 8; i++) v[i] = mb[8*b+i];
      if (!seen && v == 8'hD5) seen = 1'b1;
      mk.push_back(seen);
    end
    tag = t;
    @(negedge clk);
    pre_keep = keep_pre;
    rx_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    e = 0;
    last = cyc;
    for (int j = 0; j < nb; j++) begin
      @(negedge clk);
      if (j == flip_at) pre_keep = ~pre_keep;
      rx_bit     = mb[j];
      rx_bit_stb = 1'b1;
      @(posedge clk);
      #1;
      if (j % 2 == 1) begin
        set_exp(e);
        e++;
        last = cyc;
      end
      @(negedge clk);
      rx_bit_stb = 1'b0;
      if (j == nb - 1) rx_valid = 1'b0;
      repeat (3) @(negedge clk);
    end
    while (e <= 4 * (mnbytes + 1)) begin
      @(posedge clk);
      #1;
      if (cyc == last + 10) begin
        set_exp(e);
        e++;
        last = cyc;
      end
    end
    repeat (30) @(negedge clk);
  endtask

  initial begin
    #(8 * 60000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_valid = 1'b0; rx_bit_stb = 1'b0; rx_bit = 1'b0; pre_keep = 1'b1;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rxd !== 2'b00 || crs_dv !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rxd=%b crs_dv=%b expected rxd=00 crs_dv=0", rxd, crs_dv);
    end
    rst_n = 1'b1;
    checking = 1;
    repeat (10) @(negedge clk);

    // pass-through: preamble visible, one byte of latency, LSB-first dibits
    repeat (7) add_byte(8'h55);
    add_byte(8'hD5); add_byte(8'h3C); add_byte(8'hA1); add_byte(8'h0F);
    run_frame(1'b1, -1, "R3 R2 R7");

    // strip: crs_dv opens on the delimiter byte
    repeat (7) add_byte(8'h55);
    add_byte(8'hD5); add_byte(8'h3C); add_byte(8'hA1); add_byte(8'h0F);
    run_frame(1'b0, -1, "R4 R2 R7");

    // strip, no delimiter at all
    repeat (6) add_byte(8'h55);
    run_frame(1'b0, -1, "R6");

    // strip, delimiter shifted one bit off the byte grid
    fb.push_back(1'b0);
    repeat (7) add_byte(8'h55);
    add_byte(8'hD5); add_byte(8'h3C);
    run_frame(1'b0, -1, "R5");

    // pass-through with three trailing bits
    add_byte(8'h55); add_byte(8'hD5); add_byte(8'hAB);
    fb.push_back(1'b1); fb.push_back(1'b0); fb.push_back(1'b1);
    run_frame(1'b1, -1, "R8 R3");

    // strip, mode input toggled mid-frame
    repeat (3) add_byte(8'h55);
    add_byte(8'hD5); add_byte(8'h96); add_byte(8'h42);
    run_frame(1'b0, 20, "R9 R4");

    // strip, frame ends on an odd bit count
    repeat (2) add_byte(8'h55);
    add_byte(8'hD5); add_byte(8'hE7);
    for (int i = 0; i < 5; i++) fb.push_back(i[0]);
    run_frame(1'b0, -1, "R8 R4");

    // pass-through, single data byte
    add_byte(8'hC3);
    run_frame(1'b1, -1, "R3 R8");

    checking = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule